// File: doc/BRIEF.md
# Segmented AES Inverse Round Unit

This unit performs a reduced AES decryption round on a wide vector whose active length is chosen per request in whole 128-bit segments. The state vector and the round-key vector are combined with a bitwise XOR first. Each 128-bit segment of that sum then has the inverse row rotation applied, followed by the inverse S-box substitution. No inverse column mixing is done. All segments are processed independently and at the same time. The result takes the place of the state operand: the caller writes it back to the register that supplied the state.

A request is offered with `in_valid` and taken when `in_ready` is high. A result appears on `out_valid` a fixed two cycles after acceptance and stays there until `out_ready` takes it. Timing never depends on the data. A small sequencer controls the flow. It has three states. `ST_IDLE` waits for a request and is the only state in which `in_ready` is high. `ST_CALC` follows every acceptance; in it the substituted segments are computed from the captured operands. `ST_HOLD` presents the result. Its transitions are: IDLE→CALC on acceptance, CALC→HOLD always, HOLD→IDLE when `out_ready` is high, and HOLD→HOLD otherwise.

Top module: `aes_seg_inv_round`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is all zero.
- R2: The round key is XORed into the state before any row rotation or substitution. For example, a state byte 0x60 with key byte 0x03 produces 0x00.
- R3: Byte k of a segment sits at bits [8k+7:8k], with k = row + 4*column. The inverse row rotation moves row r right by r positions, so output row r, column c takes the summed byte from row r, column (c−r) mod 4. Row 0 does not move.
- R4: Every rotated byte passes through the AES inverse S-box. For example, 0x63→0x00, 0x7C→0x01 and 0x00→0x52.
- R5: `vl_segs` gives the number of active segments, from 1 to 16. Every active segment s is updated using key bits from segment s, with no masking of individual lanes.
- R6: Segments at or above the active count are zero in `out_data`. A count of 0 gives an all-zero result. A count above 16 acts as 16.
- R7: `out_valid` rises exactly two clock cycles after the edge at which a request is accepted, whatever the data.
- R8: `in_ready` is low from acceptance until the result is taken. A request offered in that time is ignored and does not change the pending result.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged. A result taken with `out_ready` returns the unit to idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vl_segs | input | 5 | Active vector length in 128-bit segments |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit can accept a request |
| in_state | input | 2048 | State vector operand |
| in_key | input | 2048 | Round-key vector operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 2048 | Result vector, written back in place of the state |

## Verification
Two events can fall in the same cycle: a result being taken with `out_ready` in ST_HOLD, and a new request arriving on `in_valid`. The bench raises both together on one edge. It then checks that the unit has gone idle with no request accepted and `out_valid` low. It holds the request one more cycle and checks that the result for that request, and not the earlier one, arrives two cycles after it is accepted. Results are compared against a model whose inverse S-box comes from inverting a forward S-box built by brute-force search.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;

    localparam int SEG_BITS  = 128;
    localparam int SEG_BYTES = SEG_BITS / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;

    // GF(2^8) product, reduction polynomial x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] aa;
        logic [7:0] bb;
        logic       carry;
        acc = 8'h00;
        aa  = a;
        bb  = b;
        for (int i = 0; i < 8; i++) begin
            if (bb[0]) acc = acc ^ aa;
            carry = aa[7];
            aa    = {aa[6:0], 1'b0};
            if (carry) aa = aa ^ 8'h1b;
            bb = {1'b0, bb[7:1]};
        end
        return acc;
    endfunction

    // x^254 by a fixed square-and-multiply chain; 0 maps to 0
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] p;
        logic [7:0] r;
        p = x;
        r = 8'h01;
        for (int i = 1; i < 8; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    // inverse affine map followed by field inversion
    function automatic logic [7:0] inv_sbox(input logic [7:0] s);
        logic [7:0] b;
        b = rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05;
        return gf_inv(b);
    endfunction

endpackage

// File: rtl/aes_inv_lane.sv
module aes_inv_lane
    import aes_inv_pkg::*;
(
    input  logic [SEG_BITS-1:0] lane_in,
    output logic [SEG_BITS-1:0] lane_out
);

    logic [SEG_BITS-1:0] rotated;

    for (genvar r = 0; r < 4; r++) begin : g_row
        for (genvar c = 0; c < 4; c++) begin : g_col
            localparam int DST = r + 4 * c;
            localparam int SRC = r + 4 * ((c - r + 4) % 4);
            assign rotated[8*DST +: 8] = lane_in[8*SRC +: 8];
        end
    end

    for (genvar k = 0; k < SEG_BYTES; k++) begin : g_sub
        assign lane_out[8*k +: 8] = inv_sbox(rotated[8*k +: 8]);
    end

    // R3: row 0 keeps its byte order, so column 0 of row 0 is never moved
    always_comb begin
        assert_row0_fixed_R3: assert (rotated[7:0] == lane_in[7:0]);
    end

endmodule

// File: rtl/aes_inv_seq.sv
module aes_inv_seq
    import aes_inv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic load_op,
    output logic load_res,
    output logic out_valid
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_CALC;
            ST_CALC:                state_d = ST_HOLD;
            ST_HOLD: if (out_ready) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        load_op   = 1'b0;
        load_res  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                load_op  = in_valid;
            end
            ST_CALC: load_res  = 1'b1;
            ST_HOLD: out_valid = 1'b1;
            default: ;
        endcase
    end

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##2 out_valid);

    assert_calc_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_op |=> (load_res && !in_ready));

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_hold_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

endmodule

// File: rtl/aes_seg_inv_round.sv
module aes_seg_inv_round
    import aes_inv_pkg::*;
#(
    parameter  int MAX_SEGS = 16,
    localparam int VW       = $clog2(MAX_SEGS + 1),
    localparam int DW       = MAX_SEGS * SEG_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vl_segs,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_state,
    input  logic [DW-1:0] in_key,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);

    logic          load_op;
    logic          load_res;
    logic [VW-1:0] vl_q;
    logic [DW-1:0] sum_q;
    logic [DW-1:0] res_q;
    logic [DW-1:0] lane_res;
    logic [DW-1:0] masked_res;

    aes_inv_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .load_op   (load_op),
        .load_res  (load_res),
        .out_valid (out_valid)
    );

    // stage 1: key addition across the whole vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q  <= '0;
            sum_q <= '0;
        end else if (load_op) begin
            vl_q  <= vl_segs;
            sum_q <= in_state ^ in_key;
        end
    end

    for (genvar s = 0; s < MAX_SEGS; s++) begin : g_seg
        localparam logic [VW-1:0] SIDX = VW'(s);
        logic active;
        assign active = (vl_q > SIDX);

        aes_inv_lane u_lane (
            .lane_in  (sum_q[s*SEG_BITS +: SEG_BITS]),
            .lane_out (lane_res[s*SEG_BITS +: SEG_BITS])
        );

        assign masked_res[s*SEG_BITS +: SEG_BITS] =
            active ? lane_res[s*SEG_BITS +: SEG_BITS] : '0;

        assert_tail_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && (vl_q <= SIDX)) |-> (out_data[s*SEG_BITS +: SEG_BITS] == '0));
    end

    // stage 2: rotated and substituted result, masked to active length
    always_ff @(posedge clk) begin
        if (!rst_n)        res_q <= '0;
        else if (load_res) res_q <= masked_res;
    end

    assign out_data = res_q;

    assert_data_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data));

    assert_len_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready) |=> $stable(vl_q));

endmodule

// File: tb/aes_seg_inv_round_bench.sv
module aes_seg_inv_round_bench;

    localparam int NS = 16;
    localparam int DW = NS * 128;

    typedef struct packed {
        logic [4:0] vl;
        logic [7:0] sb;
        logic [7:0] kb;
        logic [7:0] eb;
    } kat_t;

    localparam kat_t KAT [6] = '{
        '{vl: 5'd1,  sb: 8'h63, kb: 8'h00, eb: 8'h00},
        '{vl: 5'd16, sb: 8'h7C, kb: 8'h00, eb: 8'h01},
        '{vl: 5'd3,  sb: 8'h00, kb: 8'h00, eb: 8'h52},
        '{vl: 5'd8,  sb: 8'h60, kb: 8'h03, eb: 8'h00},
        '{vl: 5'd16, sb: 8'h52, kb: 8'h52, eb: 8'h52},
        '{vl: 5'd5,  sb: 8'h1F, kb: 8'h63, eb: 8'h01}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    vl_segs = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_state = '0;
    logic [DW-1:0] in_key = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;

    int errors = 0;
    int checks = 0;
    logic [7:0] inv_tab [256];

    always #5 clk = ~clk;

    aes_seg_inv_round u_aes_seg_inv_round (
        .clk(clk), .rst_n(rst_n), .vl_segs(vl_segs), .in_valid(in_valid),
        .in_ready(in_ready), .in_state(in_state), .in_key(in_key),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h11b << (i - 8));
        return prod[7:0];
    endfunction

    function automatic logic [DW-1:0] model(input logic [4:0] vl,
                                             input logic [DW-1:0] st, input logic [DW-1:0] ky);
        logic [DW-1:0] x = st ^ ky;
        logic [DW-1:0] r = '0;
        int n = (vl > 16) ? 16 : int'(vl);
        for (int s = 0; s < n; s++)
            for (int row = 0; row < 4; row++)
                for (int col = 0; col < 4; col++)
                    r[s*128 + 8*(row+4*col) +: 8] =
                        inv_tab[x[s*128 + 8*(row + 4*((col-row+4)%4)) +: 8]];
        return r;
    endfunction

    function automatic logic [DW-1:0] pattern(input int seed, input int step);
        logic [DW-1:0] v;
        for (int i = 0; i < DW/8; i++) v[8*i +: 8] = 8'((i*step + seed) & 255);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one full transaction; leaves unit idle
    task automatic do_op(input logic [4:0] vl, input logic [DW-1:0] st,
                         input logic [DW-1:0] ky, output logic [DW-1:0] got);
        @(negedge clk);
        chk(in_ready == 1'b1, "R8 idle ready", DW'(in_ready), DW'(1));
        vl_segs = vl; in_state = st; in_key = ky; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0 && in_ready == 1'b0, "R7 one cycle after accept", DW'(out_valid), DW'(0));
        @(negedge clk);
        chk(out_valid == 1'b1, "R7 two cycles after accept", DW'(out_valid), DW'(1));
        got = out_data;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 release to idle", DW'(out_valid), DW'(0));
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] got;
        logic [DW-1:0] exp;
        logic [DW-1:0] sa;
        logic [DW-1:0] ka;
        logic [DW-1:0] sb;
        logic [DW-1:0] kb;

        // reference inverse S-box: invert a forward S-box built by search
        for (int x = 0; x < 256; x++) begin
            logic [7:0] g = 8'h00;
            logic [7:0] f;
            if (x != 0) for (int y = 1; y < 256; y++) if (fmul(8'(x), 8'(y)) == 8'h01) g = 8'(y);
            f = g ^ {g[6:0], g[7]} ^ {g[5:0], g[7:6]} ^ {g[4:0], g[7:5]} ^ {g[3:0], g[7:4]} ^ 8'h63;
            inv_tab[f] = 8'(x);
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 ready", DW'(in_ready), DW'(1));
        chk(out_valid == 1'b0, "R1 valid", DW'(out_valid), DW'(0));
        chk(out_data == '0, "R1 data", out_data, '0);

        // table walk: R2 key first, R4 S-box values, R6 tail zero
        foreach (KAT[i]) begin
            sa = '0; ka = '0; exp = '0;
            for (int s = 0; s < NS; s++)
                for (int b = 0; b < 16; b++) begin
                    sa[s*128 + 8*b +: 8] = KAT[i].sb;
                    ka[s*128 + 8*b +: 8] = KAT[i].kb;
                    if (s < int'(KAT[i].vl)) exp[s*128 + 8*b +: 8] = KAT[i].eb;
                end
            do_op(KAT[i].vl, sa, ka, got);
            chk(got == exp, "R2 R4 R6 table entry", got, exp);
        end

        // R3 explicit rotation: row 1 col 0 takes byte from row 1 col 3 (index 13)
        sa = pattern(3, 17);
        do_op(5'd1, sa, '0, got);
        chk(got[8*1 +: 8] == inv_tab[sa[8*13 +: 8]], "R3 row1 col0", DW'(got[15:8]), DW'(inv_tab[sa[111:104]]));
        chk(got[8*0 +: 8] == inv_tab[sa[8*0 +: 8]], "R3 row0 unmoved", DW'(got[7:0]), DW'(inv_tab[sa[7:0]]));
        chk(got[8*2 +: 8] == inv_tab[sa[8*10 +: 8]], "R3 row2 col0", DW'(got[23:16]), DW'(inv_tab[sa[87:80]]));

        // R5 per-segment keys, several lengths
        for (int t = 0; t < 4; t++) begin
            logic [4:0] vl = (t == 0) ? 5'd16 : (t == 1) ? 5'd1 : (t == 2) ? 5'd7 : 5'd12;
            sa = pattern(11 + t, 37);
            ka = pattern(200 - t, 91);
            do_op(vl, sa, ka, got);
            exp = model(vl, sa, ka);
            chk(got == exp, "R5 segmented result", got, exp);
        end

        // R6 zero length and over-length
        sa = pattern(5, 29); ka = pattern(9, 13);
        do_op(5'd0, sa, ka, got);
        chk(got == '0, "R6 zero length", got, '0);
        do_op(5'd20, sa, ka, got);
        exp = model(5'd16, sa, ka);
        chk(got == exp, "R6 over-length acts as full", got, exp);

        // R8 request while busy is ignored
        sa = pattern(1, 3); ka = pattern(2, 5);
        sb = pattern(77, 41); kb = pattern(99, 23);
        @(negedge clk);
        vl_segs = 5'd4; in_state = sa; in_key = ka; in_valid = 1'b1;
        @(negedge clk);
        vl_segs = 5'd16; in_state = sb; in_key = kb;
        chk(in_ready == 1'b0, "R8 busy not ready", DW'(in_ready), DW'(0));
        @(negedge clk);
        chk(out_valid == 1'b1, "R7 during busy offer", DW'(out_valid), DW'(1));
        exp = model(5'd4, sa, ka);
        chk(out_data == exp, "R8 pending result unchanged", out_data, exp);
        // R9 hold while not taken
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b1 && out_data == exp, "R9 held", out_data, exp);
        // same cycle: take result and offer new request together
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R8 release with offer not accepted", DW'(in_ready), DW'(1));
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R7 accepted after idle", DW'(in_ready), DW'(0));
        @(negedge clk);
        exp = model(5'd16, sb, kb);
        chk(out_valid == 1'b1 && out_data == exp, "R7 second result", out_data, exp);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule